// File: doc/BRIEF.md
# Galois LFSR with Zero-Lock Recovery

This block is a 32-stage Galois linear feedback shift register that moves its contents one stage per clock from the top stage toward the bottom stage. In run mode the bottom stage is fed back into the top stage and XORed into three intermediate stages, so the register steps through a maximal-length pseudo-random sequence. A guard watches for the all-zero state and, in run mode, forces a 1 into the top stage so the register can never lock at zero.

A mode input switches the block into a manual load mode. There every tap is disabled, each stage takes the plain value of the stage above it, and the top stage takes a serial data bit. Thirty-two load-mode clocks therefore place any chosen pattern in the register, including all zeros. The eight lowest stages are presented on the output byte, with the bottom stage on the most significant output bit. A synchronous active-high reset clears every stage.

Top module: `lfsr_galois32`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 32 stages become 0 at that edge; `lfsr_out` reads 8'h00 afterwards.
- R2: In run mode (`load_en` = 0) every stage takes the value of the stage one position above it, and the top stage (stage 32) takes the value the bottom stage (stage 1) held before the edge, when the register is not all zero.
- R3: In run mode stages 30, 26 and 25 take the XOR of the stage above them with stage 1; all other stages below the top shift without change.
- R4: In run mode, when all 32 stages are 0, the next value of stage 32 is 1. Starting from the all-zero state, output samples 0 to 24 are 8'h00, sample 25 is 8'h01, the 1 moves one output bit up per clock and sample 32 is 8'h80; samples 50 and 51 are 8'h01 and 8'h03.
- R5: In load mode (`load_en` = 1) stage 32 takes `data_in`, every other stage takes the stage above it with no XOR, and no zero-state injection occurs: an all-zero register stays all zero. After 32 load clocks with serial bits b0 first, stage n holds b(n-1).
- R6: `lfsr_out[j]` carries stage 8-j: bit 0 is stage 8, bit 7 is stage 1.
- R7: In run mode from any nonzero state no 32-bit state repeats within the first several thousand clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all stages |
| load_en | input | 1 | 1 = manual load mode, 0 = run mode |
| data_in | input | 1 | Serial bit entering stage 32 in load mode |
| lfsr_out | output | 8 | Stages 8..1, stage 8 on bit 0 |

## Verification
Only the eight lowest stages reach the ports, so a wrong bit in an upper stage stays hidden until it has shifted down: an error in stage n first shows on `lfsr_out` n-8 clocks later, and at most 31 clocks later it has reached the feedback path and corrupts every following sample. A wrong tap position or a missing zero guard therefore appears within one register length of the first affected edge. The bench drives a cycle-exact model alongside the design and compares the output byte on every clock, and uses load mode to shift a known pattern in and read it back at the ports.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int LFSR_W  = 32;
  localparam int VIEW_W  = 8;
  // Bit i set: stage i+1 receives XOR of the stage above with the feedback.
  // Stages 30, 26 and 25 -> indices 29, 25, 24.
  localparam logic [LFSR_W-1:0] DEFAULT_TAPS = 32'h2300_0000;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_LOAD = 1'b1
  } lfsr_mode_e;
endpackage

// File: rtl/lfsr_zero_detect.sv
module lfsr_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] state_i,
  output logic         is_zero_o
);
  localparam int GROUP  = 4;
  localparam int NGROUP = (W + GROUP - 1) / GROUP;

  logic [NGROUP-1:0] grp_any;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = ((g + 1) * GROUP > W) ? W - 1 : (g + 1) * GROUP - 1;
    assign grp_any[g] = |state_i[HI:LO];
  end

  assign is_zero_o = ~|grp_any;
endmodule

// File: rtl/lfsr_next_state.sv
module lfsr_next_state
  import lfsr_pkg::*;
#(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = W'(DEFAULT_TAPS)
) (
  input  logic [W-1:0] state_i,
  input  lfsr_mode_e   mode_i,
  input  logic         serial_i,
  input  logic         is_zero_i,
  output logic [W-1:0] next_o
);
  logic fb_run;
  logic top_in;

  assign fb_run = (mode_i == MODE_RUN) & state_i[0];
  assign top_in = (mode_i == MODE_LOAD) ? serial_i : (state_i[0] | is_zero_i);

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_top
      assign next_o[i] = top_in;
    end else if (TAPS[i]) begin : g_tap
      assign next_o[i] = state_i[i+1] ^ fb_run;
    end else begin : g_plain
      assign next_o[i] = state_i[i+1];
    end
  end
endmodule

// File: rtl/lfsr_stage_reg.sv
module lfsr_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/lfsr_view.sv
module lfsr_view #(
  parameter int W   = 32,
  parameter int OUT = 8
) (
  input  logic [W-1:0]   state_i,
  output logic [OUT-1:0] view_o
);
  for (genvar j = 0; j < OUT; j++) begin : g_bit
    assign view_o[j] = state_i[OUT-1-j];
  end
endmodule

// File: rtl/lfsr_galois32.sv
module lfsr_galois32
  import lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              data_in,
  output logic [VIEW_W-1:0] lfsr_out
);
  localparam int W = LFSR_W;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         all_zero;
  lfsr_mode_e   mode;

  assign mode = load_en ? MODE_LOAD : MODE_RUN;

  lfsr_zero_detect #(.W(W)) zero_i (
    .state_i   (state_q),
    .is_zero_o (all_zero)
  );

  lfsr_next_state #(.W(W), .TAPS(DEFAULT_TAPS)) next_i (
    .state_i   (state_q),
    .mode_i    (mode),
    .serial_i  (data_in),
    .is_zero_i (all_zero),
    .next_o    (state_d)
  );

  lfsr_stage_reg #(.W(W)) reg_i (
    .clk (clk),
    .rst (rst),
    .d_i (state_d),
    .q_o (state_q)
  );

  lfsr_view #(.W(W), .OUT(VIEW_W)) view_i (
    .state_i (state_q),
    .view_o  (lfsr_out)
  );
endmodule

// File: rtl/lfsr_galois32_chk.sv
module lfsr_galois32_chk (
  input logic        clk,
  input logic        rst,
  input logic        load_en,
  input logic        data_in,
  input logic [31:0] state_q
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1: a clock with reset high leaves every stage at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    (started && $past(rst)) |-> (state_q == 32'h0));

  // R2: run-mode feedback from stage 1 into stage 32
  assert_feedback_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state_q != 32'h0) |=> (state_q[31] == $past(state_q[0])));

  // R2: bottom stage is a plain shift in run mode
  assert_bottom_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_en) |=> (state_q[0] == $past(state_q[1])));

  // R3: tap at stage 30
  assert_tap30_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en) |=> (state_q[29] == ($past(state_q[30]) ^ $past(state_q[0]))));

  // R3: tap at stage 25
  assert_tap25_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en) |=> (state_q[24] == ($past(state_q[25]) ^ $past(state_q[0]))));

  // R4: zero state escapes through stage 32
  assert_zero_escape_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state_q == 32'h0) |=> state_q[31]);

  // R4: run mode never produces the all-zero state
  assert_never_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_en) |=> (state_q != 32'h0));

  // R5: load mode is a plain serial shift
  assert_plain_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (load_en) |=> (state_q == {$past(data_in), $past(state_q[31:1])}));
endmodule

bind lfsr_galois32 lfsr_galois32_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .data_in (data_in),
  .state_q (state_q)
);

// File: tb/lfsr_galois32_tb_top.sv
`timescale 1ns/1ps
module lfsr_galois32_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic       data_in = 1'b0;
  logic [7:0] lfsr_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = 32'h0;
  bit seen [bit [31:0]];

  always #10 clk = ~clk;

  lfsr_galois32 dut_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .data_in  (data_in),
    .lfsr_out (lfsr_out)
  );

  function automatic logic [31:0] step_model(logic [31:0] s, logic ld, logic din);
    logic [31:0] n;
    logic fb;
    if (ld) return {din, s[31:1]};
    fb = s[0];
    n = s >> 1;
    n[31] = fb | (s == 32'h0);
    if (fb) n = n ^ ((32'h1 << 29) | (32'h1 << 25) | (32'h1 << 24));
    return n;
  endfunction

  function automatic logic [7:0] view_of(logic [31:0] s);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = s[7 - j];
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model = rst ? 32'h0 : step_model(model, load_en, data_in);
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] pat;
    int dup;
    // R1: reset clears
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 reset", lfsr_out, 8'h00);
    rst = 1'b0;
    load_en = 1'b0;

    // R4/R6/R3: the 100 samples after the zero state
    for (int k = 0; k < 100; k++) begin
      if (k > 0) tick();
      chk("R2 model sample", lfsr_out, view_of(model));
      if (k < 25) chk("R4 leading zeros", lfsr_out, 8'h00);
      if (k >= 25 && k <= 32) chk("R6 walking one", lfsr_out, 8'h01 << (k - 25));
      if (k == 50) chk("R3 sample50", lfsr_out, 8'h01);
      if (k == 51) chk("R3 sample51", lfsr_out, 8'h03);
    end

    // R7/R2: long run against model, state uniqueness
    dup = 0;
    for (int k = 0; k < 6000; k++) begin
      tick();
      if (lfsr_out !== view_of(model)) chk("R2 long run", lfsr_out, view_of(model));
      if (seen.exists(model)) dup++;
      seen[model] = 1'b1;
    end
    checks++;
    if (dup != 0) begin
      failures++;
      $display("FAIL R7 repeated states actual=%0d expected=0", dup);
    end

    // R5: serial load of a pattern, b0 first
    pat = 32'hA5C3_1E97;
    load_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      data_in = pat[i];
      tick();
    end
    chk("R5 loaded low byte", lfsr_out, view_of(pat));
    // R5: reveal upper stages by further plain shifts
    data_in = 1'b0;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (i % 8 == 7) chk("R5 upper stages", lfsr_out, view_of(pat >> (i + 1)));
    end

    // R3: one run step from a loaded pattern, then compare
    for (int i = 0; i < 32; i++) begin
      data_in = pat[i];
      tick();
    end
    load_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      chk("R3 taps after load", lfsr_out, view_of(model));
    end

    // R5: zero flush and no injection in load mode
    load_en = 1'b1;
    data_in = 1'b0;
    repeat (32) tick();
    for (int i = 0; i < 30; i++) tick();
    chk("R5 zero held in load mode", lfsr_out, 8'h00);
    load_en = 1'b0;
    repeat (25) tick();
    chk("R4 injection after flush", lfsr_out, 8'h01);

    // R1: reset in the middle of a run
    repeat (200) tick();
    rst = 1'b1;
    tick();
    chk("R1 mid-run reset", lfsr_out, 8'h00);
    rst = 1'b0;
    repeat (32) tick();
    chk("R6 top to bottom", lfsr_out, 8'h80);

    summary();
  end
endmodule